// File: doc/BRIEF.md
# Parallel Printer Handshake Port

This block sits between a host and an 8-bit parallel printer. The host offers one character at a time on a valid/ready input stream. When the block takes a character, it drives the character on the printer data lines and raises a busy flag. The rising edge of that flag fires a one-shot timer, and the timer drives an active-low strobe for a fixed number of clock cycles. The printer latches the data on the trailing (rising) edge of the strobe.

The block then waits for the printer's active-low acknowledge line to return high. That line is brought in through a synchroniser, and its low-to-high transition ends the transfer. This clears the busy flag and, if enabled, sets a sticky interrupt request. The interrupt lets software avoid a polling loop. A separate prime output line is driven from a plain host control pin.

Back-pressure rules: `in_ready` is low while a character is pending (busy) and while the strobe is still running. A character moves only on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the host must hold its offer and nothing is taken. `in_ready` does not depend on `in_valid`.

Top module: `prn_handshake_port`

## Requirements
- R1: After reset: `busy`=0, `irq`=0, `prn_strobe_n`=1, `prn_prime`=0, `prn_data`=0 and `in_ready`=1.
- R2: On a clock edge with `in_valid`=1 and `in_ready`=1, `in_data` appears on `prn_data` and `busy` goes to 1, both after that same edge.
- R3: `prn_strobe_n` goes low on the edge after `busy` rises. It stays low for exactly STROBE_CYCLES = CLK_KHZ*STROBE_NS/1000000 cycles (15 with the defaults 10000 kHz and 1500 ns), then returns high.
- R4: While `busy` is 1 or the strobe is low, `in_ready` is 0. An offered character is not taken, and `prn_data` keeps its value.
- R5: A low-to-high transition of `prn_ack_n` passes through a two-flop synchroniser. `busy` clears on the third clock edge after the line goes high, and not before.
- R6: An acknowledge transition while `busy` is 0 is ignored: `busy` stays 0 and `irq` is not set.
- R7: When `irq_en`=1, the acknowledge that ends a transfer sets `irq` on the same edge that clears `busy`. When `irq_en`=0, `irq` stays 0.
- R8: `irq` stays set until an edge with `irq_clr`=1. If a set and a clear fall on the same edge, the set wins.
- R9: `prn_prime` follows `prime_req` one clock edge later, independent of any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a character |
| in_ready | output | 1 | Block can take a character |
| in_data | input | DATA_W | Character offered by the host |
| irq_en | input | 1 | Enables the acknowledge interrupt |
| irq_clr | input | 1 | Clears the interrupt request |
| prime_req | input | 1 | Requested level of the prime line |
| prn_data | output | DATA_W | Data lines to the printer |
| prn_strobe_n | output | 1 | Active-low data strobe |
| prn_ack_n | input | 1 | Active-low acknowledge from the printer (asynchronous) |
| prn_prime | output | 1 | Prime (initialise) line to the printer |
| busy | output | 1 | A character is pending acknowledge |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench counts the strobe's low cycles exactly. A timer that is off by one, or that starts on the accept edge instead of on the busy edge, gives a wrong count. It offers a second character while the first is pending and checks that the data lines do not move; a design that ignored back-pressure would overwrite the character before the printer latched it. It times the acknowledge edge by edge against the synchroniser depth, sends an acknowledge with nothing pending, and holds the clear pin high through the setting edge. These catch a design with a missing or extra synchroniser stage, one that raises interrupts on stray acknowledges, and one that lets a clear override a set.

// File: rtl/prn_pkg.sv
package prn_pkg;
  function automatic int strobe_cycles(input int clk_khz, input int strobe_ns);
    longint prod;
    prod = longint'(clk_khz) * longint'(strobe_ns);
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/prn_ack_edge.sv
module prn_ack_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_async,
  output logic ack_rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], ack_n_async};
  end

  assign ack_rise = sh[STAGES-1] & ~sh[STAGES];

  // R5: an edge report is a single-cycle pulse
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |=> !ack_rise);
endmodule

// File: rtl/prn_strobe_timer.sv
module prn_strobe_timer #(
  parameter int WIDTH_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic strobe_n,
  output logic active
);
  localparam int CW = $clog2(WIDTH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active   = (cnt != '0);
  assign strobe_n = ~active;

  // R3: the count never exceeds the programmed width
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD);
  // R3: once started, the strobe stays low unless retriggered or finished
  assert_strobe_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != 1 && !trig) |=> !strobe_n);
endmodule

// File: rtl/prn_handshake_port.sv
module prn_handshake_port #(
  parameter int DATA_W    = 8,
  parameter int CLK_KHZ   = 10000,
  parameter int STROBE_NS = 1500,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic              prime_req,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe_n,
  input  logic              prn_ack_n,
  output logic              prn_prime,
  output logic              busy,
  output logic              irq
);
  import prn_pkg::*;

  localparam int STROBE_CYCLES = strobe_cycles(CLK_KHZ, STROBE_NS);
  localparam int STROBE_W      = (STROBE_CYCLES < 1) ? 1 : STROBE_CYCLES;

  logic take;
  logic busy_d;
  logic ack_rise;
  logic strobe_act;
  logic end_xfer;

  assign in_ready = ~busy & ~strobe_act;
  assign take     = in_valid & in_ready;
  assign end_xfer = ack_rise & busy;

  prn_ack_edge #(.STAGES(SYNC_STG)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_n_async (prn_ack_n),
    .ack_rise    (ack_rise)
  );

  prn_strobe_timer #(.WIDTH_CYC(STROBE_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (busy & ~busy_d),
    .strobe_n (prn_strobe_n),
    .active   (strobe_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prn_data  <= '0;
      busy      <= 1'b0;
      busy_d    <= 1'b0;
      irq       <= 1'b0;
      prn_prime <= 1'b0;
    end else begin
      busy_d    <= busy;
      prn_prime <= prime_req;
      if (take) begin
        prn_data <= in_data;
        busy     <= 1'b1;
      end else if (end_xfer) begin
        busy     <= 1'b0;
      end
      if (end_xfer && irq_en) irq <= 1'b1;
      else if (irq_clr)       irq <= 1'b0;
    end
  end

  // R2: an accepted character leaves the block busy
  assert_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  // R4: data lines hold while a character is pending
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(prn_data));
  // R3: strobe falls right after busy rises
  assert_strobe_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> $fell(prn_strobe_n));
  // R5: busy ends only through an acknowledge edge
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ack_rise));
  // R7: interrupt only from an enabled, ending acknowledge
  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(irq_en) && $past(ack_rise) && $past(busy)));
  // R8: interrupt falls only on a clear
  assert_irq_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));
endmodule

// File: tb/tb_prn_handshake_port.sv
module tb_prn_handshake_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int EXP_W = (10000 * 1500) / 1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic irq_en = 1'b0;
  logic irq_clr = 1'b0;
  logic prime_req = 1'b0;
  logic [DW-1:0] prn_data;
  logic prn_strobe_n;
  logic prn_ack_n = 1'b1;
  logic prn_prime;
  logic busy;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prn_handshake_port dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .irq_en(irq_en), .irq_clr(irq_clr),
    .prime_req(prime_req), .prn_data(prn_data), .prn_strobe_n(prn_strobe_n),
    .prn_ack_n(prn_ack_n), .prn_prime(prn_prime), .busy(busy), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offer one character; returns after the accept edge, at a negedge
  task automatic offer(input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_strobe_done();
    for (int i = 0; i < EXP_W + 4; i++) @(negedge clk);
  endtask

  // pulse ack low then raise it; returns at the negedge where the line rose
  task automatic ack_pulse();
    @(negedge clk);
    prn_ack_n = 1'b0;
    repeat (3) @(negedge clk);
    prn_ack_n = 1'b1;
  endtask

  task automatic t_reset();
    check(busy == 0, "R1 busy", busy, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(prn_strobe_n == 1, "R1 strobe", prn_strobe_n, 1);
    check(prn_prime == 0, "R1 prime", prn_prime, 0);
    check(prn_data == 0, "R1 data", prn_data, 0);
    check(in_ready == 1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_send_and_strobe();
    int low_cnt;
    offer(8'hA5);
    check(prn_data == 8'hA5, "R2 data", prn_data, 8'hA5);
    check(busy == 1, "R2 busy", busy, 1);
    check(prn_strobe_n == 1, "R3 strobe not yet", prn_strobe_n, 1);
    low_cnt = 0;
    for (int i = 0; i < EXP_W + 6; i++) begin
      @(negedge clk);
      if (!prn_strobe_n) low_cnt++;
      if (i == 0) check(prn_strobe_n == 0, "R3 strobe start", prn_strobe_n, 0);
    end
    check(low_cnt == EXP_W, "R3 strobe width", low_cnt, EXP_W);
  endtask

  task automatic t_refused();
    // still busy from the previous transfer
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h3C;
    check(in_ready == 0, "R4 in_ready busy", in_ready, 0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check(prn_data == 8'hA5, "R4 data held", prn_data, 8'hA5);
    check(busy == 1, "R4 still busy", busy, 1);
  endtask

  task automatic t_ack_timing(input bit en);
    irq_en = en;
    ack_pulse();
    @(negedge clk);
    check(busy == 1, "R5 busy after 1 edge", busy, 1);
    @(negedge clk);
    check(busy == 1, "R5 busy after 2 edges", busy, 1);
    @(negedge clk);
    check(busy == 0, "R5 busy after 3 edges", busy, 0);
    check(irq == en, "R7 irq follows enable", irq, en);
    check(in_ready == 1, "R4 ready after ack", in_ready, 1);
  endtask

  task automatic t_irq_clear();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(irq == 0, "R8 clear", irq, 0);
  endtask

  task automatic t_stray_ack();
    irq_en = 1'b1;
    ack_pulse();
    repeat (5) @(negedge clk);
    check(busy == 0, "R6 busy stays low", busy, 0);
    check(irq == 0, "R6 no irq", irq, 0);
  endtask

  task automatic t_irq_hold_and_race();
    offer(8'h5A);
    wait_strobe_done();
    irq_en = 1'b1;
    ack_pulse();
    repeat (3) @(negedge clk);
    check(irq == 1, "R7 irq set", irq, 1);
    repeat (5) @(negedge clk);
    check(irq == 1, "R8 irq held", irq, 1);
    t_irq_clear();
    // race: clear held high through the setting edge
    offer(8'h81);
    check(prn_data == 8'h81, "R2 second data", prn_data, 8'h81);
    wait_strobe_done();
    irq_clr = 1'b1;
    ack_pulse();
    repeat (3) @(negedge clk);
    check(irq == 1, "R8 set wins", irq, 1);
    @(negedge clk);
    check(irq == 0, "R8 cleared next edge", irq, 0);
    irq_clr = 1'b0;
  endtask

  task automatic t_prime();
    @(negedge clk);
    prime_req = 1'b1;
    @(negedge clk);
    check(prn_prime == 1, "R9 prime high", prn_prime, 1);
    prime_req = 1'b0;
    @(negedge clk);
    check(prn_prime == 0, "R9 prime low", prn_prime, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_send_and_strobe();
    t_refused();
    t_ack_timing(1'b0);
    offer(8'h0F);
    wait_strobe_done();
    t_ack_timing(1'b1);
    t_irq_clear();
    t_stray_ack();
    t_irq_hold_and_race();
    t_prime();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule